// File: doc/BRIEF.md
# Debug Run Controller

This block is the run-control state machine of an on-chip debug unit. When the controller is halted, a debugger issues a start command with one of four modes. The controller then raises a run enable towards the core. After every instruction the core retires, it decides whether to keep going or to halt. The core reports each retired instruction, together with whether that instruction was a call or a return. The breakpoint matcher reports hits, and a register supplies the instruction budget for bounded runs.

There are four modes. Step-into runs a single instruction. Step-over runs one instruction, but if that instruction was a call it keeps running in step-out mode until the callee returns. Step-out runs until a return brings the call nesting back out of the level the run started in. Free-run runs until the budget is spent or a breakpoint hits. A hit can come from an instruction fetch or from a data access. In either case the instruction does not commit, and the core aborts it. On every run, breakpoints are masked for the first instruction. A run that stopped on a breakpoint can therefore always resume past the instruction that caused it.

The machine has three states. HALT: run enable is low. FIRST: the first instruction of a run is in flight and breakpoints are masked. RUN: later instructions are in flight and breakpoints are live. The transitions are as follows. Launch (HALT to FIRST) happens on a start. Proceed (FIRST to RUN) happens on a retire that does not stop the run. Stop (FIRST or RUN to HALT) happens on a retire that meets the mode's stop rule. Break (RUN to HALT) happens on a live breakpoint hit. Mode codes on `mode_i` are: 0 step-into, 1 step-over, 2 step-out, 3 free-run.

Top module: `dbg_run_ctrl`

## Requirements
- R1: During and right after reset, `halted_o` is 1, and `run_en_o` and `bkpt_sup_o` are 0.
- R2: A start while halted captures `mode_i` (0 into, 1 over, 2 out, 3 free) and clears the instruction count and call depth. From the next cycle, `run_en_o` is 1, `halted_o` is 0 and `bkpt_sup_o` is 1.
- R3: In step-into mode, the first retire halts the controller. `halted_o` is 1 in the cycle after that retire.
- R4: In step-over mode, a retire with `call_i` low halts. A retire with `call_i` high continues the run in step-out mode, taking the callee as the entry level.
- R5: In step-out mode, each retired call deepens the nesting and each retired return makes it shallower. A retired return made at the entry level halts.
- R6: In free-run and step-out modes, a count of committed retires is kept since the start. The retire that brings the count to `max_iter_i` halts. With `max_iter_i` equal to 0 or 1, exactly one instruction retires.
- R7: `bkpt_sup_o` is 1 only while the first instruction of a run is in flight. A breakpoint hit during that instruction has no effect, so a run resumed onto a breakpointed instruction always makes progress.
- R8: A breakpoint hit after the first instruction halts the controller in the next cycle, in every mode. A retire in that same cycle is treated as aborted.
- R9: A start while not halted is ignored. The run keeps its captured mode.
- R10: A retire while halted is ignored, and the controller stays halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command, taken only when halted |
| mode_i | input | 2 | Run mode that goes with the start command |
| retire_i | input | 1 | Core retired an instruction this cycle |
| call_i | input | 1 | The retiring instruction is a call |
| ret_i | input | 1 | The retiring instruction is a return |
| bkpt_hit_i | input | 1 | Breakpoint matcher reports a hit (fetch or data) |
| max_iter_i | input | CNT_W | Instruction budget for bounded runs |
| run_en_o | output | 1 | Core may execute instructions |
| halted_o | output | 1 | Controller is halted |
| bkpt_sup_o | output | 1 | Breakpoint matcher must ignore hits |

## Verification
A corrupted call depth does not show until a return retires in step-out mode. At that point the halt comes one return too early or too late, and it appears on `halted_o` in the cycle after that return. A wrong instruction count shows only when the budget is reached: free-run halts at the wrong retire. This is why the budget runs cover both a cleared and a stale count. A mode register that a start wrongly overwrites mid-run shows at the next retire, where the run halts when it should continue. A state that skips the first-instruction phase shows at once as a missing `bkpt_sup_o` pulse, and then as a halt on a breakpoint held across a resume.

// File: rtl/dbg_run_pkg.sv
package dbg_run_pkg;

    typedef enum logic [1:0] {
        MODE_INTO = 2'd0,
        MODE_OVER = 2'd1,
        MODE_OUT  = 2'd2,
        MODE_FREE = 2'd3
    } run_mode_e;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_FIRST = 2'd1,
        ST_RUN   = 2'd2
    } run_state_e;

endpackage

// File: rtl/dbg_budget_ctr.sv
module dbg_budget_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             spent_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // True when the retire being counted now reaches the limit
    assign spent_o = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_i};

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R6

endmodule

// File: rtl/dbg_call_depth.sv
module dbg_call_depth #(
    parameter int DEPTH_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic deeper_i,
    input  logic shallower_i,
    output logic at_entry_o
);
    localparam logic [DEPTH_W-1:0] DEPTH_MAX = '1;

    logic [DEPTH_W-1:0] depth_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q <= '0;
        end else if (clr_i) begin
            depth_q <= '0;
        end else if (deeper_i && !shallower_i && depth_q != DEPTH_MAX) begin
            depth_q <= depth_q + 1'b1;
        end else if (shallower_i && !deeper_i && depth_q != '0) begin
            depth_q <= depth_q - 1'b1;
        end
    end

    assign at_entry_o = (depth_q == '0);

    AST_DEPTH_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (shallower_i && !deeper_i && !clr_i && depth_q == '0) |=> (depth_q == '0)); // R5

endmodule

// File: rtl/dbg_run_ctrl.sv
module dbg_run_ctrl
    import dbg_run_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int DEPTH_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic             retire_i,
    input  logic             call_i,
    input  logic             ret_i,
    input  logic             bkpt_hit_i,
    input  logic [CNT_W-1:0] max_iter_i,
    output logic             run_en_o,
    output logic             halted_o,
    output logic             bkpt_sup_o
);
    run_state_e state_q, state_d;
    run_mode_e  mode_q, mode_d;

    logic launch, bkpt_take, commit, is_call, is_ret, convert;
    logic spent, at_entry, stop;

    assign launch    = (state_q == ST_HALT) && start_i;
    assign bkpt_take = (state_q == ST_RUN) && bkpt_hit_i;
    assign commit    = (state_q != ST_HALT) && retire_i && !bkpt_take;
    assign is_call   = call_i && !ret_i;
    assign is_ret    = ret_i && !call_i;
    assign convert   = commit && (mode_q == MODE_OVER) && is_call;

    dbg_budget_ctr #(.CNT_W(CNT_W)) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (launch),
        .inc_i   (commit),
        .limit_i (max_iter_i),
        .spent_o (spent)
    );

    dbg_call_depth #(.DEPTH_W(DEPTH_W)) u_depth (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (launch),
        .deeper_i    (commit && is_call && !convert),
        .shallower_i (commit && is_ret),
        .at_entry_o  (at_entry)
    );

    // Stop rule of the captured mode, applied to a committed retire
    always_comb begin
        unique case (mode_q)
            MODE_INTO: stop = 1'b1;
            MODE_OVER: stop = !is_call || spent;
            MODE_OUT:  stop = (is_ret && at_entry) || spent;
            MODE_FREE: stop = spent;
            default:   stop = 1'b1;
        endcase
    end

    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        unique case (state_q)
            ST_HALT: begin
                if (start_i) begin
                    state_d = ST_FIRST;
                    mode_d  = run_mode_e'(mode_i);
                end
            end
            ST_FIRST, ST_RUN: begin
                if (bkpt_take) begin
                    state_d = ST_HALT;
                end else if (retire_i) begin
                    state_d = stop ? ST_HALT : ST_RUN;
                    if (convert) mode_d = MODE_OUT;
                end
            end
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            mode_q  <= MODE_INTO;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
        end
    end

    always_comb begin
        run_en_o   = (state_q != ST_HALT);
        halted_o   = (state_q == ST_HALT);
        bkpt_sup_o = (state_q == ST_FIRST);
    end

    AST_INTO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && mode_q == MODE_INTO) |=> halted_o); // R3
    AST_FIRST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en_o) |-> bkpt_sup_o); // R7
    AST_BKPT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en_o && !bkpt_sup_o && bkpt_hit_i) |=> halted_o); // R8
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_o && start_i && !retire_i && !bkpt_hit_i) |=> (!halted_o && $stable(mode_q))); // R9
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && !start_i) |=> halted_o); // R10

endmodule

// File: tb/dbg_run_ctrl_tb.sv
module dbg_run_ctrl_tb;
    localparam int CNT_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic retire_i = 1'b0, call_i = 1'b0, ret_i = 1'b0, bkpt_hit_i = 1'b0;
    logic [CNT_W-1:0] max_iter_i = '0;
    logic run_en_o, halted_o, bkpt_sup_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dbg_run_ctrl #(.CNT_W(CNT_W), .DEPTH_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .retire_i(retire_i), .call_i(call_i), .ret_i(ret_i),
        .bkpt_hit_i(bkpt_hit_i), .max_iter_i(max_iter_i),
        .run_en_o(run_en_o), .halted_o(halted_o), .bkpt_sup_o(bkpt_sup_o)
    );

    // Row: [13:10] requirement, [9] start, [8:7] mode, [6] retire, [5] call,
    // [4] ret, [3] bkpt, [2] run_en, [1] halted, [0] bkpt_sup (after the edge)
    localparam int NROW = 27;
    localparam logic [13:0] VEC [NROW] = '{
        {4'd2,  10'b1_00_0000_101}, // R2 start into
        {4'd3,  10'b0_00_1000_010}, // R3 one retire halts
        {4'd2,  10'b1_01_0000_101}, // R2 start over
        {4'd4,  10'b0_00_1000_010}, // R4 plain retire halts
        {4'd2,  10'b1_01_0000_101}, // R2 start over
        {4'd4,  10'b0_00_1100_100}, // R4 call -> step out
        {4'd5,  10'b0_00_1100_100}, // R5 nested call
        {4'd5,  10'b0_00_1010_100}, // R5 inner return
        {4'd5,  10'b0_00_1010_010}, // R5 return at entry halts
        {4'd2,  10'b1_11_0000_101}, // R2 start free run
        {4'd7,  10'b0_00_1001_100}, // R7 hit masked on first
        {4'd6,  10'b0_00_1000_100}, // R6 count 2 of 5
        {4'd8,  10'b0_00_1001_010}, // R8 live hit halts
        {4'd2,  10'b1_11_0000_101}, // R2 start free run, count cleared
        {4'd6,  10'b0_00_1000_100}, // R6 1
        {4'd6,  10'b0_00_1000_100}, // R6 2
        {4'd6,  10'b0_00_1000_100}, // R6 3
        {4'd6,  10'b0_00_1000_100}, // R6 4
        {4'd6,  10'b0_00_1000_010}, // R6 5 reaches budget
        {4'd10, 10'b0_00_1000_010}, // R10 retire while halted
        {4'd2,  10'b1_10_0000_101}, // R2 start out
        {4'd5,  10'b0_00_1010_010}, // R5 return at entry
        {4'd2,  10'b1_10_0000_101}, // R2 start out
        {4'd5,  10'b0_00_1100_100}, // R5 call
        {4'd9,  10'b1_00_0000_100}, // R9 start into while running
        {4'd9,  10'b0_00_1010_100}, // R9 still step-out after return
        {4'd5,  10'b0_00_1010_010}  // R5 return at entry halts
    };

    task automatic check(input logic [2:0] exp, input int req, input string what);
        logic [2:0] act;
        act = {run_en_o, halted_o, bkpt_sup_o};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: run/halt/sup actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic cyc(input logic st, input logic [1:0] md, input logic rt,
                       input logic cl, input logic rr, input logic bk);
        start_i = st; mode_i = md; retire_i = rt; call_i = cl; ret_i = rr; bkpt_hit_i = bk;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(3'b010, 1, "in reset"); // R1
        rst_n = 1'b1;
        @(negedge clk);
        check(3'b010, 1, "after reset"); // R1

        max_iter_i = 32'd5;
        for (int i = 0; i < NROW; i++) begin
            cyc(VEC[i][9], VEC[i][8:7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
            check(VEC[i][2:0], int'(VEC[i][13:10]), $sformatf("table row %0d", i));
        end

        // R6: zero budget still lets one instruction retire
        max_iter_i = 32'd0;
        cyc(1, 2'd3, 0, 0, 0, 0); check(3'b101, 2, "free start zero budget");
        cyc(0, 2'd0, 1, 0, 0, 0); check(3'b010, 6, "zero budget one retire");

        // R6: budget bounds step-out
        max_iter_i = 32'd3;
        cyc(1, 2'd2, 0, 0, 0, 0); check(3'b101, 2, "out start");
        cyc(0, 2'd0, 1, 1, 0, 0); check(3'b100, 6, "out call 1");
        cyc(0, 2'd0, 1, 0, 0, 0); check(3'b100, 6, "out retire 2");
        cyc(0, 2'd0, 1, 0, 0, 0); check(3'b010, 6, "out budget 3");

        // R7/R8: breakpoint held across a resume still makes progress
        max_iter_i = 32'd100;
        cyc(1, 2'd3, 0, 0, 0, 1); check(3'b101, 7, "start under hit");
        cyc(0, 2'd0, 1, 0, 0, 1); check(3'b100, 7, "first instr passes hit");
        cyc(0, 2'd0, 1, 0, 0, 1); check(3'b010, 8, "second hit halts");
        cyc(1, 2'd3, 0, 0, 0, 1); check(3'b101, 7, "resume masked");
        cyc(0, 2'd0, 1, 0, 0, 1); check(3'b100, 7, "resume progresses");
        cyc(0, 2'd0, 0, 0, 0, 1); check(3'b010, 8, "hit without retire halts");

        // R8: live hit wins over a return in step-out
        cyc(1, 2'd2, 0, 0, 0, 0); check(3'b101, 2, "out start");
        cyc(0, 2'd0, 1, 1, 0, 0); check(3'b100, 5, "out call");
        cyc(0, 2'd0, 1, 0, 1, 1); check(3'b010, 8, "hit during return");

        // R1: reset in the middle of a run
        cyc(1, 2'd3, 0, 0, 0, 0); check(3'b101, 2, "free start");
        cyc(0, 2'd0, 0, 0, 0, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check(3'b010, 1, "reset mid run");
        rst_n = 1'b1;
        @(negedge clk);
        check(3'b010, 1, "after mid-run reset");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule